// File: doc/BRIEF.md
# Two-Speed Clock Start-up Controller

This block chooses which oscillator drives the system clock after a reset or a wake from sleep. When the primary oscillator is a crystal type, the slow settling time of that crystal would otherwise hold the core in reset. The block avoids that wait by running the core at once from the internal RC clock. In parallel, a start-up timer in the primary clock domain counts edges of the crystal. When the count expires, the controller raises a status flag on a falling edge of the internal clock. It then parks the system clock low for a fixed number of primary falling edges and hands the output to the primary clock.

A sleep request cancels a start-up in progress and returns the output to the internal clock. A nonzero software clock-select value keeps the core on the internal clock and stops the sequence. When the primary mode needs no settling, or the feature is disabled, the timer is skipped and the handover starts at once. The output multiplexer uses an enable flop per source. Each enable is updated on that source's own falling edge and is cross-checked against the other source through synchronizers, so the system clock never carries a runt pulse.

Top module: `tss_clk_ctrl`

## Requirements
- R1: While `rst_n` is low, `pri_ready` is 0, `src_sel` is 2'b01 and `sys_clk` follows `clk_int`. In `src_sel`, bit 0 means the internal clock drives the output and bit 1 means the primary clock drives it.
- R2: The timed sequence applies only when `two_speed_en` is 1 and `pri_mode` is a crystal code: 3'd0, 3'd1 or 3'd2. Until the timer expires, `sys_clk` follows `clk_int` and `pri_ready` stays 0.
- R3: The start-up timer counts OST_CYCLES (default 1024) falling edges of `clk_pri`. `pri_ready` never rises before that many primary falling edges have passed since the start event. It rises within OST_CYCLES+14 of them.
- R4: `pri_ready` changes only on a falling edge of `clk_int`.
- R5: After `pri_ready` rises, `sys_clk` stays low for at least HOLD_EDGES (default 8) and at most HOLD_EDGES+4 falling edges of `clk_pri`. After that it follows `clk_pri`, with `src_sel` = 2'b10.
- R6: If `sleep_i` is high during start-up, the sequence stops, `pri_ready` stays 0 and the output stays on `clk_int`. The next `wake_i` pulse restarts the count from zero.
- R7: A nonzero `sw_sel` during start-up stops the sequence and keeps the output on `clk_int` with `pri_ready` at 0. When `sw_sel` returns to 2'b00, the count restarts from zero.
- R8: Once the primary clock drives the output, changes of `sw_sel` have no effect.
- R9: In bypass (`two_speed_en` = 0, or `pri_mode` of 3'd3 or above), `pri_ready` rises at the first falling `clk_int` edge after the start event, with no timer wait. The handover of R5 follows.
- R10: A sleep request while on the primary clock clears `pri_ready` and returns the output to `clk_int`. A wake then starts a new sequence.
- R11: `src_sel` is never 2'b11. No high or low phase of `sys_clk` is shorter than the shorter half period of the two input clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal RC clock |
| clk_pri | input | 1 | Primary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is a start event |
| wake_i | input | 1 | Wake pulse, sampled on falling `clk_int` |
| sleep_i | input | 1 | Sleep request level, sampled on falling `clk_int` |
| two_speed_en | input | 1 | Configuration bit enabling the timed start-up |
| pri_mode | input | 3 | Primary oscillator mode; 0..2 are crystal modes |
| sw_sel | input | 2 | Software clock select; nonzero forces the internal clock |
| sys_clk | output | 1 | Glitch-free system clock |
| pri_ready | output | 1 | Status flag: primary source confirmed stable and selected |
| src_sel | output | 2 | Active source: bit 0 internal, bit 1 primary |

## Verification
The bench builds the block with its default values: OST_CYCLES=1024, HOLD_EDGES=8 and SYNC_STAGES=2. This keeps the full-length timer in reach within a short run, so the exact 1024-edge lower bound is checked rather than a scaled-down copy. The internal clock runs at 50 MHz. The primary clock runs at a 14 ns period with a half-nanosecond phase offset, so edges of the two clocks never coincide. Synchronizer latency therefore shows up as a bounded spread in edge counts. With two synchronizer stages, the windows for the timer expiry and the low hold stay only a few edges wide.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
package tss_pkg;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_COUNT = 3'd1,
    ST_SWINT = 3'd2,
    ST_SLEEP = 3'd3,
    ST_PRI   = 3'd4
  } tss_state_e;

  localparam logic [2:0] MODE_LP = 3'd0;
  localparam logic [2:0] MODE_XT = 3'd1;
  localparam logic [2:0] MODE_HS = 3'd2;

  // A crystal source needs the settling count; anything else is bypassed.
  function automatic logic needs_settle(input logic en, input logic [2:0] mode);
    return en && (mode == MODE_LP || mode == MODE_XT || mode == MODE_HS);
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // True on the edge that brings a counter at 'cur' up to 'limit'.
  function automatic logic final_step(input int unsigned cur, input int unsigned limit);
    return (cur + 1) == limit;
  endfunction

endpackage

// File: rtl/tss_sync.sv
`timescale 1ns/1ps
module tss_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tss_ost.sv
`timescale 1ns/1ps
module tss_ost #(
  parameter int unsigned LIMIT       = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_pri,
  input  logic rst_n,
  input  logic run_i,   // internal-clock domain request
  output logic done_o   // primary-clock domain expiry
);
  localparam int unsigned CW = tss_pkg::cnt_bits(LIMIT);

  logic          run_s;
  logic [CW-1:0] cnt;

  tss_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk_pri), .rst_n(rst_n), .d(run_i), .q(run_s)
  );

  always_ff @(negedge clk_pri or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else if (!run_s) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      cnt    <= cnt + 1'b1;
      done_o <= tss_pkg::final_step(32'(cnt), LIMIT);
    end
  end
endmodule

// File: rtl/tss_mux.sv
`timescale 1ns/1ps
module tss_mux #(
  parameter int unsigned HOLD        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic clk_pri,
  input  logic rst_n,
  input  logic want_pri_nxt,
  output logic sys_clk,
  output logic en_int,
  output logic en_pri,
  output logic en_int_s
);
  localparam int unsigned HW = tss_pkg::cnt_bits(HOLD);

  logic          want_q;
  logic          pri_on_s;
  logic          want_s;
  logic          hold_go;
  logic [HW-1:0] hold_cnt;

  // Internal side: drop at once on request, come back only once primary is off.
  tss_sync #(.STAGES(SYNC_STAGES)) u_pri_on_sync (
    .clk(clk_int), .rst_n(rst_n), .d(en_pri), .q(pri_on_s)
  );

  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      want_q <= 1'b0;
      en_int <= 1'b1;
    end else begin
      want_q <= want_pri_nxt;
      en_int <= !want_pri_nxt && !pri_on_s;
    end
  end

  // Primary side: wait until internal is seen off, then count the low hold.
  tss_sync #(.STAGES(SYNC_STAGES)) u_want_sync (
    .clk(clk_pri), .rst_n(rst_n), .d(want_q), .q(want_s)
  );
  tss_sync #(.STAGES(SYNC_STAGES)) u_int_on_sync (
    .clk(clk_pri), .rst_n(rst_n), .d(en_int), .q(en_int_s)
  );

  assign hold_go = want_s && !en_int_s;

  always_ff @(negedge clk_pri or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      en_pri   <= 1'b0;
    end else if (!hold_go) begin
      hold_cnt <= '0;
      en_pri   <= 1'b0;
    end else if (!en_pri) begin
      hold_cnt <= hold_cnt + 1'b1;
      en_pri   <= tss_pkg::final_step(32'(hold_cnt), HOLD);
    end
  end

  assign sys_clk = (clk_int & en_int) | (clk_pri & en_pri);
endmodule

// File: rtl/tss_clk_ctrl.sv
`timescale 1ns/1ps
module tss_clk_ctrl #(
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned HOLD_EDGES  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_int,
  input  logic       clk_pri,
  input  logic       rst_n,
  input  logic       wake_i,
  input  logic       sleep_i,
  input  logic       two_speed_en,
  input  logic [2:0] pri_mode,
  input  logic [1:0] sw_sel,
  output logic       sys_clk,
  output logic       pri_ready,
  output logic [1:0] src_sel
);
  tss_pkg::tss_state_e state_q, state_d;

  // Named internal events, also observed by the bound checker.
  logic ost_done_p;
  logic ost_done_s;
  logic bypass_sel;
  logic sw_override;
  logic in_count;
  logic in_swint;
  logic want_pri_nxt;
  logic en_int;
  logic en_pri;
  logic en_int_s;

  assign bypass_sel   = !tss_pkg::needs_settle(two_speed_en, pri_mode);
  assign sw_override  = (sw_sel != 2'b00);
  assign in_count     = (state_q == tss_pkg::ST_COUNT);
  assign in_swint     = (state_q == tss_pkg::ST_SWINT);
  assign want_pri_nxt = (state_d == tss_pkg::ST_PRI);

  tss_ost #(.LIMIT(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ost (
    .clk_pri(clk_pri), .rst_n(rst_n), .run_i(in_count), .done_o(ost_done_p)
  );

  tss_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk_int), .rst_n(rst_n), .d(ost_done_p), .q(ost_done_s)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      tss_pkg::ST_START: begin
        if (sleep_i)          state_d = tss_pkg::ST_SLEEP;
        else if (bypass_sel)  state_d = tss_pkg::ST_PRI;
        else if (!ost_done_s) state_d = tss_pkg::ST_COUNT;
      end
      tss_pkg::ST_COUNT: begin
        if (sleep_i)          state_d = tss_pkg::ST_SLEEP;
        else if (sw_override) state_d = tss_pkg::ST_SWINT;
        else if (ost_done_s)  state_d = tss_pkg::ST_PRI;
      end
      tss_pkg::ST_SWINT: begin
        if (sleep_i)                          state_d = tss_pkg::ST_SLEEP;
        else if (!sw_override && !ost_done_s) state_d = tss_pkg::ST_COUNT;
      end
      tss_pkg::ST_SLEEP: begin
        if (wake_i) state_d = tss_pkg::ST_START;
      end
      tss_pkg::ST_PRI: begin
        if (sleep_i) state_d = tss_pkg::ST_SLEEP;
      end
      default: state_d = tss_pkg::ST_START;
    endcase
  end

  // All decisions land on falling edges of the internal clock.
  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) state_q <= tss_pkg::ST_START;
    else        state_q <= state_d;
  end

  assign pri_ready = (state_q == tss_pkg::ST_PRI);

  tss_mux #(.HOLD(HOLD_EDGES), .SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n),
    .want_pri_nxt(want_pri_nxt), .sys_clk(sys_clk),
    .en_int(en_int), .en_pri(en_pri), .en_int_s(en_int_s)
  );

  assign src_sel = {en_pri, en_int};
endmodule

// File: rtl/tss_chk.sv
`timescale 1ns/1ps
module tss_chk (
  input logic       clk_int,
  input logic       clk_pri,
  input logic       rst_n,
  input logic       sleep_i,
  input logic [1:0] sw_sel,
  input logic       pri_ready,
  input logic       en_int,
  input logic       en_pri,
  input logic       en_int_s,
  input logic       ost_done_s,
  input logic       bypass_sel,
  input logic       in_count,
  input logic       in_swint
);
  // R11: the two source enables are never on together (seen from either clock)
  p_src_excl_pri_r11: assert property (@(posedge clk_pri) disable iff (!rst_n)
    !(en_int && en_pri));
  p_src_excl_int_r11: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(en_int && en_pri));

  // R6: a sleep request keeps an incomplete start-up from raising the flag
  p_sleep_abort_r6: assert property (@(negedge clk_int) disable iff (!rst_n)
    (sleep_i && !pri_ready) |=> !pri_ready);

  // R7: a software select during counting parks the sequence
  p_sw_defer_r7: assert property (@(negedge clk_int) disable iff (!rst_n)
    (in_count && sw_sel != 2'b00 && !sleep_i) |=> in_swint);

  // R3 / R9: the flag rises only after timer expiry or in bypass
  p_ready_cause_r3: assert property (@(negedge clk_int) disable iff (!rst_n)
    $rose(pri_ready) |-> $past(ost_done_s || bypass_sel));

  // R5: the primary enable rises only after the internal enable was seen off
  p_hold_low_r5: assert property (@(negedge clk_pri) disable iff (!rst_n)
    $rose(en_pri) |-> ($past(!en_int_s) && $past(!en_int_s, 2)));
endmodule

bind tss_clk_ctrl tss_chk u_chk (
  .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n), .sleep_i(sleep_i),
  .sw_sel(sw_sel), .pri_ready(pri_ready), .en_int(en_int), .en_pri(en_pri),
  .en_int_s(en_int_s), .ost_done_s(ost_done_s), .bypass_sel(bypass_sel),
  .in_count(in_count), .in_swint(in_swint)
);

// File: tb/tb_tss_clk_ctrl.sv
`timescale 1ns/1ps
module tb_tss_clk_ctrl;
  localparam int OST  = 1024;
  localparam int HOLD = 8;

  logic       clk_int = 1'b0;
  logic       clk_pri = 1'b0;
  logic       rst_n   = 1'b1;
  logic       wake_i  = 1'b0;
  logic       sleep_i = 1'b0;
  logic       two_speed_en = 1'b1;
  logic [2:0] pri_mode = 3'd1;
  logic [1:0] sw_sel = 2'b00;
  wire        sys_clk;
  wire        pri_ready;
  wire  [1:0] src_sel;

  tss_clk_ctrl #(.OST_CYCLES(OST), .HOLD_EDGES(HOLD), .SYNC_STAGES(2)) dut (
    .clk_int(clk_int), .clk_pri(clk_pri), .rst_n(rst_n), .wake_i(wake_i),
    .sleep_i(sleep_i), .two_speed_en(two_speed_en), .pri_mode(pri_mode),
    .sw_sel(sw_sel), .sys_clk(sys_clk), .pri_ready(pri_ready), .src_sel(src_sel)
  );

  // 50 MHz internal clock; primary at 14 ns with a half-ns offset
  always #10 clk_int = ~clk_int;
  initial begin
    #1.5;
    forever #7 clk_pri = ~clk_pri;
  end

  int total = 0;
  int bad   = 0;

  typedef struct {
    int    kind;   // 0: flag rise, 1: first primary pulse
    int    lo;
    int    hi;
    string req;
  } exp_t;
  exp_t sbq[$];

  int  pe_cnt = 0;
  int  pe_mark = 0;
  int  hold_mark = 0;
  bit  hold_wait = 1'b0;
  bit  glitch_watch = 1'b0;
  int  glitch_cnt = 0;
  int  both_cnt = 0;
  real t_last = 0.0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic check_rng(input bit ok, input string req, input string what,
                           input int act, input int lo, input int hi);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic sb_push(input int kind, input int lo, input int hi, input string req);
    exp_t e;
    e.kind = kind; e.lo = lo; e.hi = hi; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic sb_take(input int kind, input int n);
    exp_t e;
    if (sbq.size() == 0) begin
      check(1'b0, "R6/R7", "unexpected event kind", kind, -1);
      return;
    end
    e = sbq.pop_front();
    check(e.kind == kind, e.req, "event kind", kind, e.kind);
    check_rng(n >= e.lo && n <= e.hi, e.req, "clk_pri falling edges", n, e.lo, e.hi);
  endtask

  // Monitors
  always @(negedge clk_pri) pe_cnt += 1;

  always @(posedge clk_pri) if (src_sel == 2'b11) both_cnt++;

  always @(posedge pri_ready) begin
    check(clk_int == 1'b0, "R4", "clk_int level at flag rise", int'(clk_int), 0);
    sb_take(0, pe_cnt - pe_mark);
    hold_mark = pe_cnt;
    hold_wait = 1'b1;
  end

  always @(posedge sys_clk) begin
    if (hold_wait) begin
      hold_wait = 1'b0;
      sb_take(1, pe_cnt - hold_mark);
    end
  end

  always @(sys_clk) begin
    if (glitch_watch && ($realtime - t_last) < 6.9) glitch_cnt++;
    t_last = $realtime;
  end

  // Driver helpers
  task automatic do_reset(input bit timed);
    glitch_watch = 1'b0;
    @(posedge clk_int);
    rst_n = 1'b0;
    repeat (3) @(posedge clk_int);
    if (timed) begin
      sb_push(0, OST, OST + 14, "R3");
      sb_push(1, HOLD, HOLD + 4, "R5");
    end else begin
      sb_push(0, 0, 3, "R9");
      sb_push(1, HOLD, HOLD + 4, "R9");
    end
    rst_n = 1'b1;
    pe_mark = pe_cnt;
    repeat (3) @(posedge clk_int);
    glitch_watch = 1'b1;
  endtask

  task automatic pulse_wake();
    @(posedge clk_int);
    wake_i = 1'b1;
    pe_mark = pe_cnt;
    @(posedge clk_int);
    wake_i = 1'b0;
  endtask

  task automatic wait_primary(input string req);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk_int);
      #2;
      if (src_sel == 2'b10) break;
    end
    repeat (4) @(posedge clk_int);
    #2;
    check(src_sel == 2'b10, req, "src_sel on primary", int'(src_sel), 2);
    check(pri_ready == 1'b1, req, "pri_ready on primary", int'(pri_ready), 1);
  endtask

  task automatic expect_internal(input string req);
    @(posedge clk_int);
    #2;
    check(pri_ready == 1'b0, req, "pri_ready", int'(pri_ready), 0);
    check(src_sel == 2'b01, req, "src_sel", int'(src_sel), 1);
  endtask

  initial begin
    // R1: reset state
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk_int);
    #2;
    check(pri_ready == 1'b0, "R1", "pri_ready in reset", int'(pri_ready), 0);
    check(src_sel == 2'b01, "R1", "src_sel in reset", int'(src_sel), 1);
    check(sys_clk == 1'b1, "R1", "sys_clk while clk_int high", int'(sys_clk), 1);

    // R2, R3, R5: timed start-up in XT mode
    do_reset(1'b1);
    repeat (400) @(posedge clk_int);
    expect_internal("R2");
    wait_primary("R5");

    // R8: software select ignored on primary
    @(posedge clk_int) sw_sel = 2'b11;
    repeat (60) @(posedge clk_int);
    #2;
    check(src_sel == 2'b10, "R8", "src_sel with sw_sel=11", int'(src_sel), 2);
    check(pri_ready == 1'b1, "R8", "pri_ready with sw_sel=11", int'(pri_ready), 1);
    @(posedge clk_int) sw_sel = 2'b00;

    // R10: sleep on primary returns to internal
    @(posedge clk_int) sleep_i = 1'b1;
    repeat (20) @(posedge clk_int);
    expect_internal("R10");

    // R6: wake, then sleep mid-count aborts; no flag expected
    sleep_i = 1'b0;
    pulse_wake();
    repeat (300) @(posedge clk_int);
    sleep_i = 1'b1;
    repeat (800) @(posedge clk_int);
    expect_internal("R6");
    sleep_i = 1'b0;
    sb_push(0, OST, OST + 14, "R6");
    sb_push(1, HOLD, HOLD + 4, "R6");
    pulse_wake();
    wait_primary("R6");

    // R7: software select mid-count parks the sequence
    @(posedge clk_int) sleep_i = 1'b1;
    repeat (20) @(posedge clk_int);
    sleep_i = 1'b0;
    pulse_wake();
    repeat (300) @(posedge clk_int);
    sw_sel = 2'b01;
    repeat (800) @(posedge clk_int);
    expect_internal("R7");
    sb_push(0, OST, OST + 14, "R7");
    sb_push(1, HOLD, HOLD + 4, "R7");
    @(posedge clk_int);
    sw_sel = 2'b00;
    pe_mark = pe_cnt;
    wait_primary("R7");

    // R2: HS crystal mode also takes the timed path
    pri_mode = 3'd2;
    do_reset(1'b1);
    wait_primary("R2");

    // R9: bypass with the enable off
    two_speed_en = 1'b0;
    pri_mode = 3'd1;
    do_reset(1'b0);
    wait_primary("R9");

    // R9: bypass with a non-crystal mode
    two_speed_en = 1'b1;
    pri_mode = 3'd5;
    do_reset(1'b0);
    wait_primary("R9");

    repeat (20) @(posedge clk_int);
    check(sbq.size() == 0, "R3", "pending expected events", sbq.size(), 0);
    check(glitch_cnt == 0, "R11", "short sys_clk phases", glitch_cnt, 0);
    check(both_cnt == 0, "R11", "src_sel=11 samples", both_cnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule